// File: doc/BRIEF.md
# DPLL Operating Mode Controller

This block sequences a digital phase-locked loop through its operating states. At reset the loop runs free. Once a reference is present, the loop moves into acquisition. It reaches the locked state only after the lock detector has held steady for a qualification time. After that it watches for phase loss and for the reference going away. When the loop can no longer track and no stand-by reference is usable, it falls back to holdover and freezes the frequency word. A separate acquisition state leads out of holdover, so that a failed re-acquisition returns to holdover rather than to free-run.

The outputs are:
- the mode code;
- the loop bandwidth code the filter should use;
- a freeze line for the loop filter;
- a one-cycle request to the reference selector to swap to the stand-by input;
- a sticky interrupt that is raised on every change of mode.

A non-zero mode override pins the machine in a chosen state. All timing is counted in ticks of `tick_i`, a slow time base supplied from outside.

Top module: `dpll_mode_ctrl`

## Requirements
- R1: While `rst_ni` is low and after reset, `mode_o` is 1 (free-run), and `irq_o`, `freeze_o` and `switch_o` are low.
- R2: Mode codes are 1 free-run, 2 holdover, 3 locked, 4 acquiring, 5 acquiring-from-holdover, 6 phase-lost. Free-run moves to code 4 on the clock edge after `ref_valid_i` is seen high.
- R3: In code 4 or 5, the machine moves to code 3 on the QUAL_TICKS-th tick during which `lock_det_i` was high. Any cycle with `lock_det_i` low restarts the count.
- R4: In code 4 or 5, either `ref_valid_i` low or ACQ_TICKS ticks without locking causes a fallback. If `standby_valid_i` is high, the machine enters code 4 and pulses `switch_o`. Otherwise code 4 goes to free-run and code 5 goes to holdover. `ref_valid_i` low takes priority over locking, and locking takes priority over the timeout.
- R5: Code 3 moves to code 6 while `phase_lost_i` is high. Code 6 returns to code 3 when `phase_lost_i` drops. Code 6 falls back after LOSS_TICKS ticks, and codes 3 and 6 also fall back when `ref_valid_i` is low. This fallback goes to code 4 with a `switch_o` pulse if a stand-by is valid, and to holdover otherwise.
- R6: Holdover is left only for code 5, on the edge after `ref_valid_i` is seen high.
- R7: A `force_mode_i` value of 1 to 6 sets `mode_o` to that code at the next edge and stops automatic sequencing. Values 0 and 7 select automatic operation.
- R8: `bw_o` takes `lock_bw_i` in codes 3 and 6, and `acq_bw_i` in all other codes. `acq_sel_o` is high when the acquisition code is in use. Codes are 0 = 18 Hz, 1 = 35 Hz, 2 = 70 Hz, and 3 is delivered as 2.
- R9: `freeze_o` is high exactly while `mode_o` is 2.
- R10: `irq_o` is set by every change of `mode_o` and stays set until a cycle with `irq_clr_i` high. A mode change in the same cycle as a clear leaves it set.
- R11: `switch_o` is a single-cycle pulse. It appears only in the cycle after `standby_valid_i` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_valid_i | input | 1 | Current reference is valid |
| standby_valid_i | input | 1 | A stand-by reference is valid |
| lock_det_i | input | 1 | Lock detector output |
| phase_lost_i | input | 1 | Phase-loss detector output |
| tick_i | input | 1 | Time-base tick for all timers |
| force_mode_i | input | 3 | 0 or 7 automatic, 1..6 forced mode code |
| acq_bw_i | input | 2 | Acquisition bandwidth code |
| lock_bw_i | input | 2 | Locked bandwidth code |
| irq_clr_i | input | 1 | Clears the sticky interrupt |
| mode_o | output | 3 | Current mode code |
| bw_o | output | 2 | Bandwidth code to the loop filter |
| acq_sel_o | output | 1 | Acquisition bandwidth selected |
| freeze_o | output | 1 | Hold the frequency word |
| switch_o | output | 1 | Request swap to stand-by reference |
| irq_o | output | 1 | Sticky mode-change interrupt |

## Verification
A wrong state register shows on `mode_o`, `bw_o` and `freeze_o` in the same cycle, because these outputs decode the state directly. A miscounting timer stays invisible until the first tick at which the bench expects a transition. At that tick `mode_o` then moves a cycle early or late, or not at all. An error in the stand-by decision shows one cycle after the fallback, as a missing or extra `switch_o` pulse or as the wrong fallback mode. A wrong interrupt rule shows as `irq_o` disagreeing with the expected value in the cycle after a mode change or a clear.

// File: rtl/dpll_mode_pkg.sv
package dpll_mode_pkg;

  typedef enum logic [2:0] {
    MODE_FREE = 3'd1,
    MODE_HOLD = 3'd2,
    MODE_LOCK = 3'd3,
    MODE_PRE  = 3'd4,
    MODE_PRE2 = 3'd5,
    MODE_LOST = 3'd6
  } mode_e;

  localparam logic [1:0] BW_18HZ = 2'd0;
  localparam logic [1:0] BW_35HZ = 2'd1;
  localparam logic [1:0] BW_70HZ = 2'd2;

  function automatic logic is_forced(logic [2:0] code);
    return (code != 3'd0) && (code != 3'd7);
  endfunction

  function automatic logic [1:0] bw_clamp(logic [1:0] code);
    return (code == 2'd3) ? BW_70HZ : code;
  endfunction

endpackage

// File: rtl/dpll_tick_timer.sv
module dpll_tick_timer #(
  parameter int unsigned LIMIT = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  input  logic tick_i,
  output logic hit_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i || !run_i)   cnt_q <= '0;
    else if (tick_i && cnt_q != CW'(LIMIT)) cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = run_i && tick_i && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/dpll_mode_fsm.sv
module dpll_mode_fsm
  import dpll_mode_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ref_valid_i,
  input  logic       standby_valid_i,
  input  logic       phase_lost_i,
  input  logic [2:0] force_mode_i,
  input  logic       qual_hit_i,
  input  logic       acq_hit_i,
  input  logic       loss_hit_i,
  output mode_e      mode_o,
  output logic       restart_o,
  output logic       mode_chg_o,
  output logic       switch_o
);
  mode_e state_q, state_d;
  logic  sw_d, forced;

  assign forced = is_forced(force_mode_i);

  always_comb begin
    state_d = state_q;
    sw_d    = 1'b0;
    if (forced) begin
      state_d = mode_e'(force_mode_i);
    end else begin
      unique case (state_q)
        MODE_FREE: if (ref_valid_i) state_d = MODE_PRE;
        MODE_PRE, MODE_PRE2: begin
          if (!ref_valid_i || (!qual_hit_i && acq_hit_i)) begin
            if (standby_valid_i) begin
              state_d = MODE_PRE;
              sw_d    = 1'b1;
            end else begin
              state_d = (state_q == MODE_PRE) ? MODE_FREE : MODE_HOLD;
            end
          end else if (qual_hit_i) begin
            state_d = MODE_LOCK;
          end
        end
        MODE_LOCK, MODE_LOST: begin
          if (!ref_valid_i || (state_q == MODE_LOST && phase_lost_i && loss_hit_i)) begin
            state_d = standby_valid_i ? MODE_PRE : MODE_HOLD;
            sw_d    = standby_valid_i;
          end else if (state_q == MODE_LOCK && phase_lost_i) begin
            state_d = MODE_LOST;
          end else if (state_q == MODE_LOST && !phase_lost_i) begin
            state_d = MODE_LOCK;
          end
        end
        MODE_HOLD: if (ref_valid_i) state_d = MODE_PRE2;
        default:   state_d = MODE_FREE;
      endcase
    end
  end

  assign mode_chg_o = (state_d != state_q);
  assign restart_o  = mode_chg_o || sw_d || forced;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= MODE_FREE;
      switch_o <= 1'b0;
    end else begin
      state_q  <= state_d;
      switch_o <= sw_d;
    end
  end

  assign mode_o = state_q;
endmodule

// File: rtl/dpll_mode_out.sv
module dpll_mode_out
  import dpll_mode_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  mode_e      mode_i,
  input  logic       mode_chg_i,
  input  logic       irq_clr_i,
  input  logic [1:0] acq_bw_i,
  input  logic [1:0] lock_bw_i,
  output logic [1:0] bw_o,
  output logic       acq_sel_o,
  output logic       freeze_o,
  output logic       irq_o
);
  logic irq_q;

  assign acq_sel_o = !(mode_i == MODE_LOCK || mode_i == MODE_LOST);
  assign bw_o      = acq_sel_o ? bw_clamp(acq_bw_i) : bw_clamp(lock_bw_i);
  assign freeze_o  = (mode_i == MODE_HOLD);

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= (irq_q && !irq_clr_i) || mode_chg_i;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/dpll_mode_ctrl.sv
module dpll_mode_ctrl
  import dpll_mode_pkg::*;
#(
  parameter int unsigned QUAL_TICKS = 8,
  parameter int unsigned ACQ_TICKS  = 20,
  parameter int unsigned LOSS_TICKS = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ref_valid_i,
  input  logic       standby_valid_i,
  input  logic       lock_det_i,
  input  logic       phase_lost_i,
  input  logic       tick_i,
  input  logic [2:0] force_mode_i,
  input  logic [1:0] acq_bw_i,
  input  logic [1:0] lock_bw_i,
  input  logic       irq_clr_i,
  output logic [2:0] mode_o,
  output logic [1:0] bw_o,
  output logic       acq_sel_o,
  output logic       freeze_o,
  output logic       switch_o,
  output logic       irq_o
);
  mode_e mode;
  logic  restart, mode_chg, in_pre, in_lost;
  logic  qual_hit, acq_hit, loss_hit;

  assign in_pre  = (mode == MODE_PRE) || (mode == MODE_PRE2);
  assign in_lost = (mode == MODE_LOST);

  dpll_tick_timer #(.LIMIT(QUAL_TICKS)) u_qual_tmr (
    .clk_i, .rst_ni, .run_i(in_pre && lock_det_i), .clr_i(restart),
    .tick_i, .hit_o(qual_hit)
  );

  dpll_tick_timer #(.LIMIT(ACQ_TICKS)) u_acq_tmr (
    .clk_i, .rst_ni, .run_i(in_pre), .clr_i(restart),
    .tick_i, .hit_o(acq_hit)
  );

  dpll_tick_timer #(.LIMIT(LOSS_TICKS)) u_loss_tmr (
    .clk_i, .rst_ni, .run_i(in_lost), .clr_i(restart),
    .tick_i, .hit_o(loss_hit)
  );

  dpll_mode_fsm u_fsm (
    .clk_i, .rst_ni, .ref_valid_i, .standby_valid_i, .phase_lost_i,
    .force_mode_i, .qual_hit_i(qual_hit), .acq_hit_i(acq_hit),
    .loss_hit_i(loss_hit), .mode_o(mode), .restart_o(restart),
    .mode_chg_o(mode_chg), .switch_o
  );

  dpll_mode_out u_out (
    .clk_i, .rst_ni, .mode_i(mode), .mode_chg_i(mode_chg), .irq_clr_i,
    .acq_bw_i, .lock_bw_i, .bw_o, .acq_sel_o, .freeze_o, .irq_o
  );

  assign mode_o = mode;
endmodule

// File: rtl/dpll_mode_chk.sv
module dpll_mode_chk
  import dpll_mode_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ref_valid_i,
  input logic       standby_valid_i,
  input logic [2:0] force_mode_i,
  input logic       irq_clr_i,
  input logic [2:0] mode_o,
  input logic       freeze_o,
  input logic       switch_o,
  input logic       irq_o
);
  logic auto_m;
  assign auto_m = !is_forced(force_mode_i);

  assert_forced_mode_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_forced(force_mode_i) |=> mode_o == $past(force_mode_i));

  assert_irq_on_change_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mode_o) |-> irq_o);

  assert_irq_holds_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_clr_i) |=> irq_o);

  assert_hold_exit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_m && mode_o == MODE_HOLD) |=> (mode_o == MODE_HOLD || mode_o == MODE_PRE2));

  assert_freeze_kept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freeze_o && auto_m && !ref_valid_i) |=> freeze_o);

  assert_free_stays_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_m && mode_o == MODE_FREE && !ref_valid_i) |=> mode_o == MODE_FREE);

  assert_lock_entry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_m && mode_o != MODE_PRE && mode_o != MODE_PRE2 &&
     mode_o != MODE_LOST && mode_o != MODE_LOCK) |=> mode_o != MODE_LOCK);

  assert_switch_standby_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    switch_o |-> $past(standby_valid_i));

  assert_switch_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    switch_o |-> mode_o == MODE_PRE);
endmodule

bind dpll_mode_ctrl dpll_mode_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ref_valid_i(ref_valid_i),
  .standby_valid_i(standby_valid_i), .force_mode_i(force_mode_i),
  .irq_clr_i(irq_clr_i), .mode_o(mode_o), .freeze_o(freeze_o),
  .switch_o(switch_o), .irq_o(irq_o)
);

// File: tb/dpll_mode_ctrl_tb.sv
module dpll_mode_ctrl_tb;
  localparam int PERIOD = 10;
  localparam int QUAL = 8;
  localparam int ACQ  = 20;
  localparam int LOSS = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_v = 0, sby_v = 0, lock = 0, plost = 0, tick = 0, clr = 0;
  logic [2:0] force_m = 0;
  logic [1:0] acq_bw = 2'd2, lock_bw = 2'd0;
  logic [2:0] mode;
  logic [1:0] bw;
  logic acq_sel, freeze, sw, irq;

  int total = 0, bad = 0, cyc_n = 0;
  bit sparse = 0;
  string cur_req = "R2";

  // reference model state
  int m_mode = 1, m_qual = 0, m_acq = 0, m_loss = 0, nxt;
  bit m_irq = 0, m_sw = 0, pre, qh, ah, lh, forced, sw_n, restart;

  always #(PERIOD/2) clk = ~clk;

  dpll_mode_ctrl #(.QUAL_TICKS(QUAL), .ACQ_TICKS(ACQ), .LOSS_TICKS(LOSS)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ref_valid_i(ref_v), .standby_valid_i(sby_v),
    .lock_det_i(lock), .phase_lost_i(plost), .tick_i(tick), .force_mode_i(force_m),
    .acq_bw_i(acq_bw), .lock_bw_i(lock_bw), .irq_clr_i(clr),
    .mode_o(mode), .bw_o(bw), .acq_sel_o(acq_sel), .freeze_o(freeze),
    .switch_o(sw), .irq_o(irq)
  );

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic void fallback(bit from_pre1);
    if (sby_v) begin nxt = 4; sw_n = 1; end
    else nxt = from_pre1 ? 1 : 2;
  endfunction

  always @(negedge clk) begin
    cyc_n++;
    tick <= sparse ? (cyc_n % 3 == 0) : 1'b1;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 1; m_qual = 0; m_acq = 0; m_loss = 0; m_irq = 0; m_sw = 0;
    end else begin
      pre = (m_mode == 4 || m_mode == 5);
      qh = pre && lock && tick && (m_qual == QUAL - 1);
      ah = pre && tick && (m_acq == ACQ - 1);
      lh = (m_mode == 6) && tick && (m_loss == LOSS - 1);
      forced = (force_m >= 1 && force_m <= 6);
      sw_n = 0; nxt = m_mode;
      if (forced) nxt = force_m;
      else if (m_mode == 1) begin if (ref_v) nxt = 4; end
      else if (pre) begin
        if (!ref_v) fallback(m_mode == 4);
        else if (qh) nxt = 3;
        else if (ah) fallback(m_mode == 4);
      end else if (m_mode == 3) begin
        if (!ref_v) fallback(0);
        else if (plost) nxt = 6;
      end else if (m_mode == 6) begin
        if (!ref_v) fallback(0);
        else if (!plost) nxt = 3;
        else if (lh) fallback(0);
      end else if (m_mode == 2) begin
        if (ref_v) nxt = 5;
      end
      restart = (nxt != m_mode) || sw_n || forced;
      m_irq = (m_irq && !clr) || (nxt != m_mode);
      if (restart) begin m_qual = 0; m_acq = 0; m_loss = 0; end
      else begin
        m_qual = (pre && lock) ? m_qual + int'(tick) : 0;
        m_acq  = pre ? m_acq + int'(tick) : 0;
        m_loss = (m_mode == 6) ? m_loss + int'(tick) : 0;
      end
      m_sw = sw_n;
      m_mode = nxt;
    end
  end

  // compare a quarter period after each rising edge
  always @(posedge clk) begin
    if (rst_n) begin
      int ebw;
      bit elk;
      #(PERIOD/4);
      elk = (m_mode == 3 || m_mode == 6);
      ebw = elk ? ((lock_bw == 3) ? 2 : lock_bw) : ((acq_bw == 3) ? 2 : acq_bw);
      check(cur_req, "mode", mode, m_mode);
      check("R8", "bw", bw, ebw);
      check("R8", "acq_sel", acq_sel, !elk);
      check("R9", "freeze", freeze, m_mode == 2);
      check("R10", "irq", irq, m_irq);
      check("R11", "switch", sw, m_sw);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(3);
    check("R1", "reset mode", mode, 1);
    check("R1", "reset irq", irq, 0);
    check("R1", "reset freeze", freeze, 0);
    check("R1", "reset switch", sw, 0);
    rst_n = 1;
    cyc(3);
    check("R1", "post reset mode", mode, 1);
    cur_req = "R2"; ref_v = 1; cyc(3);
    cur_req = "R3"; lock = 1; cyc(3); lock = 0; cyc(1); lock = 1; cyc(12);
    lock_bw = 2'd3; acq_bw = 2'd1; cyc(2);
    cur_req = "R5"; plost = 1; cyc(3); plost = 0; cyc(2);
    plost = 1; cyc(3); ref_v = 0; cyc(4);
    cur_req = "R6"; plost = 0; lock = 0; cyc(3); ref_v = 1; cyc(3);
    lock = 1; cyc(QUAL + 3);
    cur_req = "R5"; plost = 1; cyc(LOSS + 4); plost = 0; cyc(QUAL + 4);
    cur_req = "R4"; lock = 0; ref_v = 0; sby_v = 1; cyc(1); ref_v = 1; cyc(ACQ + 3);
    sby_v = 0; cyc(ACQ + 3);
    acq_bw = 2'd3; sparse = 1; lock = 1; cyc(3 * QUAL + 6); sparse = 0;
    lock = 0; cur_req = "R7"; force_m = 3'd2; cyc(2);
    cur_req = "R4"; force_m = 3'd0; cyc(ACQ + 4);
    cur_req = "R7";
    for (int f = 1; f <= 7; f++) begin
      force_m = f[2:0]; lock_bw = f[1:0]; cyc(3);
    end
    force_m = 3'd0; cyc(3);
    cur_req = "R10"; clr = 1; cyc(1); clr = 0; cyc(2);
    clr = 1; force_m = 3'd3; cyc(1); force_m = 3'd6; cyc(1); clr = 0; cyc(2);
    force_m = 3'd0; clr = 1; cyc(2); clr = 0; cyc(3);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule